// File: doc/BRIEF.md
# Serial Register Access Port

This block is a host-facing synchronous serial slave that gives a controller read and write access to a bank of sixteen 8-bit registers. The lower registers hold configuration, which the block presents as a flat output vector to the rest of the chip. The upper registers are read-only status, whose values come in on an input vector. The host frames each transaction with an active-low select. It toggles a serial clock and shifts data in on one pin. Read data returns on an output whose enable goes low whenever the port must not drive the line, so a pad or an external buffer can tri-state it.

A transaction starts with one control byte. The control byte carries a read/write flag, a 4-bit register address, two reserved bits and a burst flag. Data bytes follow it. In a single access one data byte moves and anything after it is ignored. When the burst flag is set and the address is zero, the port streams through every register in ascending order. The host signals are asynchronous to the core clock. All three are brought in through multi-stage synchronisers and sampled in the core domain, so the host clock must run well below the core clock.

Top module: `hostport_regs`

## Requirements
- R1: After reset every configuration byte on `cfg_out` is 0x00 and `sdo_oe` is low.
- R2: All bits move LSB first. The host changes `sdi` while `sclk` is low, and the port samples it on the rising `sclk` edge. In the control byte, bit 0 is the direction (0 = write), bits 4:1 are the register address and bit 7 is the burst flag. A write to an address below NUM_CFG (default 12) updates that register, and the register appears at `cfg_out[8*addr +: 8]`.
- R3: For a read (control bit 0 = 1), the port drives the first data bit after the falling edge that ends the control byte. It drives each later bit after the next falling edge, so the host samples `sdo` just before each rising edge.
- R4: Addresses NUM_CFG to 15 read back `status_in[8*(addr-NUM_CFG) +: 8]`, sampled when the byte is loaded. Writes to those addresses change nothing.
- R5: `sdo_oe` is low while `cs_n` is high and throughout write transactions.
- R6: While `cs_n` is high, `sclk` and `sdi` activity has no effect. The next selected transaction is framed from its first bit.
- R7: A control byte with bit 5 or bit 6 set is invalid. The rest of that transaction writes nothing and never enables `sdo`.
- R8: With the burst flag set and address 0, consecutive data bytes access registers 0, 1, ... 15 in order, for both reads and writes.
- R9: With the burst flag set and a nonzero address, the access is treated as a single access.
- R10: In a single access, bytes after the first data byte are ignored. For a read, `sdo_oe` drops after the falling edge that follows the last data bit.
- R11: If `cs_n` rises before a data byte is complete, that partial byte is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Host select, active low |
| sclk | input | 1 | Host serial clock |
| sdi | input | 1 | Host serial data in |
| sdo | output | 1 | Serial data out, valid while `sdo_oe` is high |
| sdo_oe | output | 1 | Output enable for `sdo`; low means high impedance |
| status_in | input | 8*(16-NUM_CFG) | Read-only status bytes, lowest byte at address NUM_CFG |
| cfg_out | output | 8*NUM_CFG | Configuration register contents, register 0 in the low byte |

## Verification
The bench runs single writes and reads at low, middle and status addresses, with data chosen so that bit-order or address-field errors show up. Burst writes and burst reads from address zero confirm that the address advances and stops at the last register. A burst flag paired with a nonzero address is used to confirm that the flag is gated. Reserved-bit control bytes, extra trailing bytes, clocking with the select high, and an aborted half byte are used to separate correct discarding from stray writes or a driven output.

// File: rtl/hostport_pkg.sv
package hostport_pkg;
  localparam int HP_DW   = 8;
  localparam int HP_AW   = 4;
  localparam int HP_REGS = 1 << HP_AW;
  localparam int HP_BW   = $clog2(HP_DW);

  // control byte field positions (decoded by the shift engine)
  localparam int CTL_RW      = 0;
  localparam int CTL_ADDR_LO = 1;
  localparam int CTL_RSV_LO  = 5;
  localparam int CTL_RSV_HI  = 6;
  localparam int CTL_BURST   = 7;

  typedef enum logic [1:0] {
    PH_CTRL = 2'd0,
    PH_DATA = 2'd1,
    PH_DONE = 2'd2
  } hp_phase_e;
endpackage

// File: rtl/hostport_sync.sv
module hostport_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= RST_VAL;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hostport_shift.sv
module hostport_shift
  import hostport_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             sclk_s,
  input  logic             sdi_s,
  input  logic [HP_DW-1:0] rd_data,
  output logic [HP_AW-1:0] rd_addr,
  output logic             wr_en,
  output logic [HP_AW-1:0] wr_addr,
  output logic [HP_DW-1:0] wr_data,
  output logic             sdo,
  output logic             sdo_oe
);
  hp_phase_e        phase;
  logic             sclk_q;
  logic [HP_BW-1:0] bit_cnt;
  logic [HP_BW-1:0] out_cnt;
  logic [HP_DW-1:0] shreg;
  logic [HP_DW-1:0] rd_byte;
  logic [HP_AW-1:0] addr_q;
  logic             is_read;
  logic             burst;
  logic             rd_live;

  logic             rise, fall, last_bit;
  logic [HP_DW-1:0] full_byte;
  logic [HP_AW-1:0] ctl_addr;
  logic             ctl_bad;

  always_comb begin
    rise      = active & sclk_s & ~sclk_q;
    fall      = active & ~sclk_s & sclk_q;
    last_bit  = (bit_cnt == HP_BW'(HP_DW-1));
    full_byte = {sdi_s, shreg[HP_DW-1:1]};
    ctl_addr  = full_byte[CTL_ADDR_LO +: HP_AW];
    ctl_bad   = full_byte[CTL_RSV_LO] | full_byte[CTL_RSV_HI];
    rd_addr   = (phase == PH_CTRL) ? ctl_addr : addr_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b0;
    else     sclk_q <= sclk_s;
  end

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      phase   <= PH_CTRL;
      bit_cnt <= '0;
      out_cnt <= '0;
      shreg   <= '0;
      rd_byte <= '0;
      addr_q  <= '0;
      is_read <= 1'b0;
      burst   <= 1'b0;
      rd_live <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      sdo     <= 1'b0;
      sdo_oe  <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (rise) begin
        shreg   <= full_byte;
        bit_cnt <= bit_cnt + 1'b1;
        if (last_bit) begin
          unique case (phase)
            PH_CTRL: begin
              if (ctl_bad) begin
                phase <= PH_DONE;
              end else begin
                phase   <= PH_DATA;
                is_read <= full_byte[CTL_RW];
                addr_q  <= ctl_addr;
                burst   <= full_byte[CTL_BURST] & (ctl_addr == '0);
                if (full_byte[CTL_RW]) begin
                  rd_byte <= rd_data;
                  rd_live <= 1'b1;
                  out_cnt <= '0;
                end
              end
            end
            PH_DATA: begin
              if (!is_read) begin
                wr_en   <= 1'b1;
                wr_addr <= addr_q;
                wr_data <= full_byte;
              end
              if (burst && addr_q != HP_AW'(HP_REGS-1)) begin
                addr_q <= addr_q + 1'b1;
                if (is_read) begin
                  rd_byte <= rd_data;
                  out_cnt <= '0;
                end
              end else begin
                phase   <= PH_DONE;
                rd_live <= 1'b0;
              end
            end
            default: ;
          endcase
        end
      end
      if (fall) begin
        if (rd_live) begin
          sdo     <= rd_byte[out_cnt];
          sdo_oe  <= 1'b1;
          out_cnt <= out_cnt + 1'b1;
        end else begin
          sdo_oe <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/hostport_bank.sv
module hostport_bank
  import hostport_pkg::*;
#(
  parameter int NUM_CFG = 12,
  localparam int NUM_STS = HP_REGS - NUM_CFG
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [HP_AW-1:0]         wr_addr,
  input  logic [HP_DW-1:0]         wr_data,
  input  logic [HP_AW-1:0]         rd_addr,
  output logic [HP_DW-1:0]         rd_data,
  input  logic [NUM_STS*HP_DW-1:0] status_in,
  output logic [NUM_CFG*HP_DW-1:0] cfg_out
);
  logic [HP_DW-1:0] cfg_mem [NUM_CFG];
  logic [HP_DW-1:0] rd_tbl  [HP_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CFG; i++) cfg_mem[i] <= '0;
    end else if (wr_en && int'(wr_addr) < NUM_CFG) begin
      cfg_mem[wr_addr] <= wr_data;
    end
  end

  generate
    for (genvar g = 0; g < HP_REGS; g++) begin : g_map
      if (g < NUM_CFG) begin : g_cfg
        assign rd_tbl[g] = cfg_mem[g];
        assign cfg_out[g*HP_DW +: HP_DW] = cfg_mem[g];
      end else begin : g_sts
        assign rd_tbl[g] = status_in[(g-NUM_CFG)*HP_DW +: HP_DW];
      end
    end
  endgenerate

  assign rd_data = rd_tbl[rd_addr];
endmodule

// File: rtl/hostport_regs.sv
module hostport_regs
  import hostport_pkg::*;
#(
  parameter int NUM_CFG     = 12,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_STS = HP_REGS - NUM_CFG
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cs_n,
  input  logic                     sclk,
  input  logic                     sdi,
  output logic                     sdo,
  output logic                     sdo_oe,
  input  logic [NUM_STS*HP_DW-1:0] status_in,
  output logic [NUM_CFG*HP_DW-1:0] cfg_out
);
  logic [2:0]       pins_s;
  logic             wr_en;
  logic [HP_AW-1:0] wr_addr, rd_addr;
  logic [HP_DW-1:0] wr_data, rd_data;

  hostport_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d({cs_n, sclk, sdi}), .q(pins_s)
  );

  hostport_shift u_shift (
    .clk(clk), .rst(rst), .active(~pins_s[2]), .sclk_s(pins_s[1]),
    .sdi_s(pins_s[0]), .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  hostport_bank #(.NUM_CFG(NUM_CFG)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .status_in(status_in), .cfg_out(cfg_out)
  );
endmodule

// File: rtl/hostport_regs_chk.sv
module hostport_regs_chk
  import hostport_pkg::*;
#(
  parameter int NUM_CFG = 12
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     cs_n,
  input logic                     sdo_oe,
  input logic                     wr_en,
  input logic [HP_AW-1:0]         wr_addr,
  input logic [HP_DW-1:0]         wr_data,
  input logic [NUM_CFG*HP_DW-1:0] cfg_out
);
  assert_oe_idle_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(cs_n,1) && $past(cs_n,2) && $past(cs_n,3) && $past(cs_n,4)) |-> !sdo_oe);

  assert_no_write_deselected_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(cs_n,1) && $past(cs_n,2) && $past(cs_n,3) && $past(cs_n,4)) |-> !wr_en);

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && int'(wr_addr) < NUM_CFG) |=>
      cfg_out[$past(wr_addr)*HP_DW +: HP_DW] == $past(wr_data));

  assert_status_write_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && int'(wr_addr) >= NUM_CFG) |=> $stable(cfg_out));
endmodule

bind hostport_regs hostport_regs_chk #(.NUM_CFG(NUM_CFG)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .sdo_oe(sdo_oe), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .cfg_out(cfg_out)
);

// File: tb/hostport_regs_bench.sv
module hostport_regs_bench;
  localparam int NCFG = 12;
  localparam int NSTS = 16 - NCFG;
  localparam int HALF = 6;

  logic clk = 0, rst = 1, cs_n = 1, sclk = 0, sdi = 0;
  logic sdo, sdo_oe;
  logic [NSTS*8-1:0] status_in = 32'hD4C3B2A1;
  logic [NCFG*8-1:0] cfg_out;

  int checks = 0, errors = 0, cs_hi_run = 0;
  bit done = 0;
  logic [7:0] model [16];

  always #4 clk = ~clk;

  hostport_regs u_hostport_regs (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .status_in(status_in), .cfg_out(cfg_out)
  );

  task automatic check(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison of output enable against the idle rule
  always @(negedge clk) begin
    if (rst) cs_hi_run = 0;
    else begin
      cs_hi_run = cs_n ? cs_hi_run + 1 : 0;
      if (cs_hi_run >= 6) check(sdo_oe === 1'b0, "R5 oe while deselected", 96'(sdo_oe), 96'd0);
    end
  end

  function automatic logic [7:0] ctl(bit rd, int a, bit b, logic [1:0] rsv);
    return {b, rsv, 4'(a), rd};
  endfunction

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output logic any_oe);
    any_oe = 0;
    for (int i = 0; i < 8; i++) begin
      sdi = tx[i];
      wait_n(HALF);
      rx[i] = sdo;
      any_oe = any_oe | sdo_oe;
      sclk = 1;
      wait_n(HALF);
      sclk = 0;
    end
  endtask

  task automatic sel;   cs_n = 0; wait_n(HALF); endtask
  task automatic desel; wait_n(HALF); cs_n = 1; wait_n(12); endtask

  task automatic cmp_cfg(input string tag);
    logic [NCFG*8-1:0] exp;
    for (int i = 0; i < NCFG; i++) exp[i*8 +: 8] = model[i];
    check(cfg_out === exp, tag, 96'(cfg_out), 96'(exp));
  endtask

  task automatic wr1(int a, logic [7:0] d);
    logic [7:0] rx; logic oe;
    sel; xfer(ctl(0, a, 0, 2'b00), rx, oe); xfer(d, rx, oe); desel;
    if (a < NCFG) model[a] = d;
    check(oe === 1'b0, "R5 oe during write", 96'(oe), 96'd0);
  endtask

  task automatic rd1(int a, string tag);
    logic [7:0] rx; logic oe;
    sel; xfer(ctl(1, a, 0, 2'b00), rx, oe); xfer(8'h00, rx, oe); desel;
    check(rx === model[a], tag, 96'(rx), 96'(model[a]));
  endtask

  initial begin
    logic [7:0] rx; logic oe;
    for (int i = 0; i < 16; i++) model[i] = (i < NCFG) ? 8'h00 : status_in[(i-NCFG)*8 +: 8];
    wait_n(5); rst = 0; wait_n(3);
    // R1 reset state
    cmp_cfg("R1 reset cfg");
    check(sdo_oe === 1'b0, "R1 reset oe", 96'(sdo_oe), 96'd0);

    // R2 single writes with asymmetric data, R3 reads back
    wr1(0, 8'h01); wr1(5, 8'hB4); wr1(11, 8'h80);
    cmp_cfg("R2 single writes");
    rd1(5, "R3 read addr5"); rd1(11, "R3 read addr11"); rd1(0, "R3 read addr0");

    // R4 status read and ignored write
    rd1(12, "R4 status addr12"); rd1(15, "R4 status addr15");
    wr1(13, 8'h55);
    cmp_cfg("R4 status write no cfg change");
    rd1(13, "R4 status unchanged after write");

    // R6 clocking while deselected
    for (int i = 0; i < 8; i++) begin
      sdi = ctl(0, 7, 0, 2'b00) >> i; wait_n(HALF); sclk = 1; wait_n(HALF); sclk = 0;
    end
    for (int i = 0; i < 8; i++) begin
      sdi = i[0]; wait_n(HALF); sclk = 1; wait_n(HALF); sclk = 0;
    end
    wait_n(10);
    cmp_cfg("R6 deselected clocks ignored");
    wr1(7, 8'h3C); cmp_cfg("R6 framing after deselected clocks");

    // R7 reserved bits
    sel; xfer(ctl(0, 2, 0, 2'b01), rx, oe); xfer(8'hEE, rx, oe); desel;
    cmp_cfg("R7 bad ctrl no write");
    sel; xfer(ctl(1, 5, 0, 2'b10), rx, oe); xfer(8'h00, rx, oe); desel;
    check(oe === 1'b0, "R7 bad ctrl no drive", 96'(oe), 96'd0);

    // R8 burst write then burst read
    sel; xfer(ctl(0, 0, 1, 2'b00), rx, oe);
    for (int i = 0; i < 16; i++) begin
      xfer(8'(8'h30 + i*7), rx, oe);
      if (i < NCFG) model[i] = 8'(8'h30 + i*7);
    end
    desel;
    cmp_cfg("R8 burst write");
    sel; xfer(ctl(1, 0, 1, 2'b00), rx, oe);
    for (int i = 0; i < 16; i++) begin
      xfer(8'h00, rx, oe);
      check(rx === model[i], "R8 burst read", 96'(rx), 96'(model[i]));
    end
    desel;

    // R9 burst flag with nonzero address
    sel; xfer(ctl(0, 3, 1, 2'b00), rx, oe); xfer(8'hA5, rx, oe); xfer(8'h5A, rx, oe); desel;
    model[3] = 8'hA5;
    cmp_cfg("R9 gated burst single write");

    // R10 trailing bytes ignored, oe released after read
    sel; xfer(ctl(0, 4, 0, 2'b00), rx, oe); xfer(8'h11, rx, oe); xfer(8'h22, rx, oe); desel;
    model[4] = 8'h11;
    cmp_cfg("R10 trailing write ignored");
    sel; xfer(ctl(1, 4, 0, 2'b00), rx, oe); xfer(8'h00, rx, oe);
    check(rx === 8'h11, "R10 read data", 96'(rx), 96'h11);
    xfer(8'h00, rx, oe);
    check(oe === 1'b0, "R10 oe after read", 96'(oe), 96'd0);
    desel;

    // R11 aborted byte
    sel; xfer(ctl(0, 2, 0, 2'b00), rx, oe);
    for (int i = 0; i < 4; i++) begin
      sdi = 1; wait_n(HALF); sclk = 1; wait_n(HALF); sclk = 0;
    end
    desel;
    cmp_cfg("R11 partial byte dropped");
    rd1(2, "R11 read after abort");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule